// File: doc/BRIEF.md
# IR carrier PWM waveform generator

This block builds an infrared or PWM waveform out of two timed segments: an active (high) segment and a quiet (low) segment, each with its own 8-bit duration and its own prescaler. Once the function is switched on, the output moves between the two segments without stopping. The active segment can be a steady high level, or it can carry a square wave from a separate carrier divider. A low-only mode drops the active segment completely, so that only the low duration sets the timing.

Software programs the block through a simple write port: an address, a data byte and a strobe. Seven locations are decoded: 0 control, 1 prescaler selects, 2 high duration, 3 low duration, 4 carrier divider, 5 flags, 6 interrupt enables. Writes to address 7 do nothing. The block drives the output level and its output-enable. Each segment has a sticky expiry flag, and one interrupt line combines the two flags.

Control bits at address 0: bit0 run, bit1 carrier gate, bit2 low priority, bit3 pin enable, bit4 high timer enable, bit5 low timer enable, bit6 carrier enable.

Top module: `ir_pwm_gen`

## Requirements
- R1: After reset every register and flag is 0. While run (address 0 bit0) is 0, `irOut` is 1 and both flags hold their value.
- R2: When run is 1 and both prescalers select 0, the high segment lasts (high duration + 1) cycles with `irOut`=1. The low segment that follows lasts (low duration + 1) cycles with `irOut`=0, and the two repeat. The first segment is the high segment. Counting starts at the clock edge after the edge that writes run=1.
- R3: Address 1 bits [2:0] select the high prescaler and bits [6:4] select the low prescaler. A select value p makes the timer advance once every 2^p cycles. The advance happens on cycles where the low p bits of a free-running 7-bit prescaler count are all ones. That count is held at 0 while run is 0.
- R4: With carrier gate (bit1) at 1, the high segment outputs the carrier level. The carrier starts at 0 when run is set and, while carrier enable (bit6) is 1, toggles every (divider + 1) cycles. With bit1 at 0, the high segment outputs a plain 1.
- R5: When low priority (bit2) and carrier gate (bit1) are both 1, the high segment is skipped. Low segments repeat, `irOut` stays 0 and the high flag is never set.
- R6: A duration written while a segment is running takes effect at the next segment boundary.
- R7: A segment expiry sets its flag: high flag = `hiFlag`, low flag = `loFlag`. The flags stay set until a write to address 5 with a 0 in the flag's bit (bit0 high, bit1 low). If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` equals (`hiFlag` AND address 6 bit0) OR (`loFlag` AND address 6 bit1).
- R9: When the running segment's timer enable (bit4 high, bit5 low) is 0, that segment holds its remaining count.
- R10: `irOutEn` follows pin enable (bit3). A write to address 7 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| irOut | output | 1 | Waveform output |
| irOutEn | output | 1 | Output-pin enable |
| hiFlag | output | 1 | High-segment expiry flag |
| loFlag | output | 1 | Low-segment expiry flag |
| irq | output | 1 | Enabled flag interrupt |

## Verification
Every output comes straight from registers through gates, with no register on the way out. A write or expiry that lands on clock edge N therefore shows up on the outputs right after edge N. For example, `irq` changes right after the edge that writes the enables, and a new segment level appears right after the edge where the count was zero. The bench changes its inputs and compares all outputs on falling edges. A behavioural model steps at each rising edge from the same sampled inputs and keeps its own counters and queue-free integer state. The comparison therefore always lines up with the first cycle in which a result is due. The scenarios cover several duration and prescaler patterns, the change of a duration mid-segment, carrier gating, stalled timers, low-only mode and the flag clear and enable writes.

// File: rtl/ir_pwm_pkg.sv
package ir_pwm_pkg;
  parameter int DUR_W     = 8;
  parameter int PRE_SEL_W = 3;
  parameter int ADDR_W    = 3;
  localparam int PRE_CNT_W = (1 << PRE_SEL_W) - 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HIW   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOW   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CDIV  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IE    = 3'd6;

  typedef struct packed {
    logic                 irOn;
    logic                 gate;
    logic                 lowPri;
    logic                 pinEn;
    logic                 hiEn;
    logic                 loEn;
    logic                 carEn;
    logic [PRE_SEL_W-1:0] hiPre;
    logic [PRE_SEL_W-1:0] loPre;
    logic [DUR_W-1:0]     hiWidth;
    logic [DUR_W-1:0]     loWidth;
    logic [DUR_W-1:0]     carDiv;
  } cfg_t;

  typedef struct packed {
    logic             idle;
    logic             load;
    logic             dec;
    logic [DUR_W-1:0] loadVal;
  } stb_t;
endpackage

// File: rtl/ir_pwm_datapath.sv
module ir_pwm_datapath
  import ir_pwm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfg,
  input  stb_t stb,
  output logic tickHi,
  output logic tickLo,
  output logic cntZero,
  output logic carLvl
);
  logic [PRE_CNT_W-1:0] preCnt;
  logic [DUR_W-1:0]     durCnt;
  logic [DUR_W-1:0]     carCnt;
  logic [PRE_CNT_W-1:0] tapMask [2];
  logic [1:0]           tapHit;

  // one mask per timer: low p bits of the shared prescaler count
  for (genvar g = 0; g < 2; g++) begin : gTap
    logic [PRE_SEL_W-1:0] sel;
    assign sel = (g == 0) ? cfg.hiPre : cfg.loPre;
    assign tapMask[g] = PRE_CNT_W'((1 << sel) - 1);
    assign tapHit[g]  = (preCnt & tapMask[g]) == tapMask[g];
  end

  assign tickHi  = tapHit[0];
  assign tickLo  = tapHit[1];
  assign cntZero = (durCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      durCnt <= '0;
      carCnt <= '0;
      carLvl <= 1'b0;
    end else begin
      preCnt <= stb.idle ? '0 : preCnt + 1'b1;
      if (stb.load)     durCnt <= stb.loadVal;
      else if (stb.dec) durCnt <= durCnt - 1'b1;
      if (stb.idle) begin
        carCnt <= '0;
        carLvl <= 1'b0;
      end else if (cfg.carEn) begin
        if (carCnt == cfg.carDiv) begin
          carCnt <= '0;
          carLvl <= ~carLvl;
        end else begin
          carCnt <= carCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_pwm_ctrl.sv
module ir_pwm_ctrl
  import ir_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUR_W-1:0]  wrData,
  input  logic              tickHi,
  input  logic              tickLo,
  input  logic              cntZero,
  input  logic              carLvl,
  output cfg_t              cfg,
  output stb_t              stb,
  output logic              segHigh,
  output logic              irOut,
  output logic              irOutEn,
  output logic              hiFlag,
  output logic              loFlag,
  output logic              irq
);
  logic [1:0] ieBits;
  logic       lowOnly, advance, segEnd, nextHigh, flagWr;

  assign lowOnly  = cfg.lowPri & cfg.gate;
  assign advance  = cfg.irOn & (segHigh ? (tickHi & cfg.hiEn) : (tickLo & cfg.loEn));
  assign segEnd   = advance & cntZero;
  assign nextHigh = segHigh ? 1'b0 : ~lowOnly;
  assign flagWr   = wrEn && (wrAddr == A_FLAG);

  always_comb begin
    stb.idle    = ~cfg.irOn;
    stb.load    = ~cfg.irOn | segEnd;
    stb.dec     = advance & ~cntZero;
    if (~cfg.irOn) stb.loadVal = lowOnly ? cfg.loWidth : cfg.hiWidth;
    else           stb.loadVal = nextHigh ? cfg.hiWidth : cfg.loWidth;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      ieBits <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: {cfg.carEn, cfg.loEn, cfg.hiEn, cfg.pinEn,
                 cfg.lowPri, cfg.gate, cfg.irOn} <= wrData[6:0];
        A_PRE:  begin
                  cfg.hiPre <= wrData[PRE_SEL_W-1:0];
                  cfg.loPre <= wrData[4 +: PRE_SEL_W];
                end
        A_HIW:  cfg.hiWidth <= wrData;
        A_LOW:  cfg.loWidth <= wrData;
        A_CDIV: cfg.carDiv  <= wrData;
        A_IE:   ieBits      <= wrData[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segHigh <= 1'b1;
      hiFlag  <= 1'b0;
      loFlag  <= 1'b0;
    end else begin
      if (~cfg.irOn)  segHigh <= ~lowOnly;
      else if (segEnd) segHigh <= nextHigh;
      hiFlag <= (segEnd & segHigh)  | (hiFlag & ~(flagWr & ~wrData[0]));
      loFlag <= (segEnd & ~segHigh) | (loFlag & ~(flagWr & ~wrData[1]));
    end
  end

  always_comb begin
    if (~cfg.irOn)   irOut = 1'b1;
    else if (segHigh) irOut = cfg.gate ? carLvl : 1'b1;
    else              irOut = 1'b0;
  end

  assign irOutEn = cfg.pinEn;
  assign irq     = (hiFlag & ieBits[0]) | (loFlag & ieBits[1]);
endmodule

// File: rtl/ir_pwm_gen.sv
module ir_pwm_gen
  import ir_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUR_W-1:0]  wrData,
  output logic              irOut,
  output logic              irOutEn,
  output logic              hiFlag,
  output logic              loFlag,
  output logic              irq
);
  cfg_t cfg;
  stb_t stb;
  logic segHigh, tickHi, tickLo, cntZero, carLvl;

  ir_pwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickHi(tickHi), .tickLo(tickLo), .cntZero(cntZero), .carLvl(carLvl),
    .cfg(cfg), .stb(stb), .segHigh(segHigh), .irOut(irOut), .irOutEn(irOutEn),
    .hiFlag(hiFlag), .loFlag(loFlag), .irq(irq)
  );

  ir_pwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .tickHi(tickHi), .tickLo(tickLo), .cntZero(cntZero), .carLvl(carLvl)
  );
endmodule

// File: rtl/ir_pwm_chk.sv
module ir_pwm_chk
  import ir_pwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DUR_W-1:0]  wrData,
  input logic              irOn,
  input logic              gate,
  input logic              lowPri,
  input logic              segHigh,
  input logic              irOut,
  input logic              hiFlag,
  input logic              loFlag,
  input logic              irq
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !irOn |-> irOut);

  a_r2_low_seg_low: assert property (@(posedge clk) disable iff (!rstN)
    (irOn && !segHigh) |-> !irOut);

  a_r4_plain_high: assert property (@(posedge clk) disable iff (!rstN)
    (irOn && segHigh && !gate) |-> irOut);

  a_r5_no_hi_flag: assert property (@(posedge clk) disable iff (!rstN)
    (irOn && gate && lowPri && !segHigh) |=> !$rose(hiFlag));

  a_r7_hi_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (hiFlag && !(wrEn && wrAddr == A_FLAG && !wrData[0])) |=> hiFlag);

  a_r7_lo_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (loFlag && !(wrEn && wrAddr == A_FLAG && !wrData[1])) |=> loFlag);

  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (hiFlag || loFlag));
endmodule

bind ir_pwm_gen ir_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irOn(cfg.irOn), .gate(cfg.gate), .lowPri(cfg.lowPri), .segHigh(segHigh),
  .irOut(irOut), .hiFlag(hiFlag), .loFlag(loFlag), .irq(irq)
);

// File: tb/ir_pwm_gen_tb.sv
module ir_pwm_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irOut, irOutEn, hiFlag, loFlag, irq;

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  string phaseReq = "R1";

  always #2 clk = ~clk;

  ir_pwm_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irOut(irOut), .irOutEn(irOutEn), .hiFlag(hiFlag), .loFlag(loFlag), .irq(irq)
  );

  // behavioural model state
  int mCtl, mPreSel, mHiW, mLoW, mDiv, mIe;
  int mCnt, mPc, mCar;
  bit mHigh, mLvl, mHf, mLf;
  bit lowOnly, adv, tHi, tLo, setHi, setLo, nHigh;
  int hp, lp;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl = 0; mPreSel = 0; mHiW = 0; mLoW = 0; mDiv = 0; mIe = 0;
      mCnt = 0; mPc = 0; mCar = 0; mHigh = 1; mLvl = 0; mHf = 0; mLf = 0;
    end else begin
      lowOnly = mCtl[2] && mCtl[1];
      setHi = 0; setLo = 0;
      if (!mCtl[0]) begin
        mHigh = !lowOnly;
        mCnt  = mHigh ? mHiW : mLoW;
        mPc = 0; mCar = 0; mLvl = 0;
      end else begin
        hp  = mPreSel % 8;
        lp  = (mPreSel / 16) % 8;
        tHi = (mPc % (1 << hp)) == (1 << hp) - 1;
        tLo = (mPc % (1 << lp)) == (1 << lp) - 1;
        adv = mHigh ? (tHi && mCtl[4]) : (tLo && mCtl[5]);
        if (adv) begin
          if (mCnt == 0) begin
            if (mHigh) setHi = 1; else setLo = 1;
            nHigh = mHigh ? 0 : !lowOnly;
            mHigh = nHigh;
            mCnt  = nHigh ? mHiW : mLoW;
          end else mCnt = mCnt - 1;
        end
        mPc = (mPc + 1) % 128;
        if (mCtl[6]) begin
          if (mCar == mDiv) begin mCar = 0; mLvl = !mLvl; end
          else mCar = mCar + 1;
        end
      end
      if (wrEn && wrAddr == 5) begin
        if (!wrData[0]) mHf = 0;
        if (!wrData[1]) mLf = 0;
      end
      if (setHi) mHf = 1;
      if (setLo) mLf = 1;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mCtl = wrData & 8'h7F;
          3'd1: mPreSel = wrData & 8'h77;
          3'd2: mHiW = wrData;
          3'd3: mLoW = wrData;
          3'd4: mDiv = wrData;
          3'd6: mIe = wrData & 3;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string name, logic act, bit exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", phaseReq, name, act, exp, $time);
    end
  endtask

  // compare all outputs on every falling edge
  always @(negedge clk) begin
    bit expOut;
    if (!done) begin
      if (!mCtl[0])   expOut = 1;
      else if (mHigh) expOut = mCtl[1] ? mLvl : 1;
      else            expOut = 0;
      cmp("irOut", irOut, expOut);
      cmp("irOutEn(R10)", irOutEn, mCtl[3]);
      cmp("hiFlag(R7)", hiFlag, mHf);
      cmp("loFlag(R7)", loFlag, mLf);
      cmp("irq(R8)", irq, (mHf && mIe[0]) || (mLf && mIe[1]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    phaseReq = "R1";
    idle(4);
    rstN = 1;
    idle(6);
    // R2: plain alternation, no prescale
    phaseReq = "R2";
    wr(2, 8'd3);
    wr(3, 8'd5);
    wr(0, 8'h39);
    idle(60);
    // R7: clear only the high flag, then R8 enables
    phaseReq = "R7";
    wr(5, 8'h02);
    idle(4);
    phaseReq = "R8";
    wr(6, 8'h03);
    idle(20);
    wr(5, 8'h00);
    wr(6, 8'h02);
    idle(20);
    // R3: prescaled timers
    phaseReq = "R3";
    wr(1, 8'h12);
    idle(150);
    // R6: width change mid-segment
    phaseReq = "R6";
    wr(2, 8'd1);
    idle(3);
    wr(3, 8'd2);
    idle(60);
    // R4: carrier gating
    phaseReq = "R4";
    wr(1, 8'h00);
    wr(4, 8'd2);
    wr(0, 8'h7B);
    idle(80);
    // R9: high timer stalled, then resumed
    phaseReq = "R9";
    wr(0, 8'h6B);
    idle(30);
    wr(0, 8'h7B);
    idle(20);
    // R10: write to unused address
    phaseReq = "R10";
    wr(7, 8'hFF);
    idle(10);
    // R5: low-only mode
    phaseReq = "R5";
    wr(0, 8'h7F);
    wr(5, 8'h00);
    idle(60);
    // R1: disable holds output high
    phaseReq = "R1";
    wr(0, 8'h48);
    idle(20);
    finishRun();
  end
endmodule